// File: doc/BRIEF.md
# UART Register Bank with Interrupt Combining

This block is the software-facing register file of a serial port. It sits on a simple word-addressed bus with a byte address, a write enable with write data, and a read strobe. Read data comes back registered, one cycle after the strobe. The block holds the settings that the rest of the port uses: the baud divisors, the low-power divisor, line control, control, FIFO level select and DMA control. It also keeps a raw interrupt status, an interrupt mask and a receive error status, and it mirrors the FIFO flags that the transmit and receive paths report.

Data-register accesses are not stored here. A write to the data slot is passed to the transmit path as a one-cycle push carrying the byte. A read of the data slot is passed to the receive FIFO as a one-cycle pop, and the word the FIFO presents is returned. The receive FIFO reports when its fill level reaches the trigger point and when it drops below it, and those pulses move the receive interrupt. The raw status and the mask combine into a single level-sensitive interrupt line.

A fixed window at the top of the 4 KB space returns eight identification bytes, one per word. Serial shifting, baud generation and DMA transfers belong to other blocks.

Top module: `uart_regbank`

## Requirements
- R1: After synchronous active-high reset, FIFO level select reads 0x12, control reads 0x300 and flags read 0x90. Every other register, `irq` and `bus_rdata` read zero.
- R2: Register index is byte address bits [11:2]. The plain settings registers are index 8 (8 bits), 9 (16 bits), 10 (6 bits), 11 (8 bits), 12 (16 bits), 13 (6 bits) and 18 (3 bits). Each one reads back the last written value masked to its width, and holds it when it is not written.
- R3: A write to index 0 pulses `tx_push` in the same cycle with `tx_byte` equal to write data [7:0]. From the next cycle it sets raw status bit 5 (transmit).
- R4: A read strobe to index 0 pulses `rx_pop` in the same cycle. The next cycle `bus_rdata` holds `rx_word` zero-extended, and the receive status takes `rx_word[11:8]`.
- R5: Index 1 reads the receive status in bits [3:0]. Any write to index 1 clears it to zero.
- R6: Index 6 reads the flags, sampled one cycle earlier: bit 7 `txp_empty`, bit 6 `rxf_full`, bit 5 `txp_full`, bit 4 `rxf_empty`. Writes to index 6 change nothing.
- R7: An `rxf_hit` pulse sets raw bit 4 (receive) and an `rxf_drop` pulse clears it. When both arrive in the same cycle, set wins.
- R8: A write to index 17 clears every raw status bit that is 1 in the write data. A set event in the same cycle wins over the clear.
- R9: Index 14 is the 11-bit interrupt mask (read/write), index 15 is the raw status and index 16 is raw AND mask. Writes to 15 and 16 change nothing.
- R10: `irq` is high exactly when raw AND mask is non-zero, from the cycle after the change.
- R11: Byte addresses 0xFE0 through 0xFFF return, for word k = address[4:2], the bytes 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 for k = 0..7. Writes there change nothing.
- R12: Reads of any other address return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after the strobe |
| tx_push | output | 1 | Byte handed to the transmit path |
| tx_byte | output | 8 | Byte for the transmit path |
| txp_empty | input | 1 | Transmit path empty |
| txp_full | input | 1 | Transmit path full |
| rx_pop | output | 1 | Word taken from the receive FIFO |
| rx_word | input | RXW_W | Receive FIFO head: byte plus error bits |
| rxf_empty | input | 1 | Receive FIFO empty |
| rxf_full | input | 1 | Receive FIFO full |
| rxf_hit | input | 1 | Receive fill reached the trigger point |
| rxf_drop | input | 1 | Receive fill fell below the trigger point |
| irq | output | 1 | Combined level-sensitive interrupt |

## Verification
A wrong raw-status or mask bit shows on `irq` in the very next cycle, and it shows on a read of index 15 or 16 one cycle after the strobe. The bench therefore checks `irq` after every operation against its own model of raw and mask. A lost or misplaced settings bit, or a decode that aliases two indices, stays hidden until that register is read. The random mix of reads over all 32 low indices, the identification window and addresses far outside the map exposes it within a few hundred operations. Same-cycle collisions between a clear write and a set event are driven on purpose, because a wrong priority leaves no trace until the interrupt is next examined.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;
  localparam int DATA_W = 32;
  localparam int IRQ_W  = 11;
  localparam int NCFG   = 7;
  localparam int BIT_TXI = 5;
  localparam int BIT_RXI = 4;

  localparam logic [4:0] IDX_DATA = 5'd0;
  localparam logic [4:0] IDX_RSR  = 5'd1;
  localparam logic [4:0] IDX_FLAG = 5'd6;
  localparam logic [4:0] IDX_MSK  = 5'd14;
  localparam logic [4:0] IDX_RAW  = 5'd15;
  localparam logic [4:0] IDX_MIS  = 5'd16;
  localparam logic [4:0] IDX_ICL  = 5'd17;

  // Settings registers: slot k -> register index
  function automatic logic [4:0] cfg_index(input int k);
    case (k)
      0: return 5'd8;
      1: return 5'd9;
      2: return 5'd10;
      3: return 5'd11;
      4: return 5'd12;
      5: return 5'd13;
      default: return 5'd18;
    endcase
  endfunction

  function automatic int cfg_width(input int k);
    case (k)
      0: return 8;
      1: return 16;
      2: return 6;
      3: return 8;
      4: return 16;
      5: return 6;
      default: return 3;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] cfg_mask(input int k);
    return DATA_W'((64'd1 << cfg_width(k)) - 64'd1);
  endfunction

  function automatic logic [DATA_W-1:0] cfg_reset(input int k);
    case (k)
      4: return DATA_W'(32'h300);
      5: return DATA_W'(32'h12);
      default: return '0;
    endcase
  endfunction

  function automatic logic [7:0] id_byte(input logic [2:0] k);
    case (k)
      3'd0: return 8'h11;
      3'd1: return 8'h10;
      3'd2: return 8'h14;
      3'd3: return 8'h00;
      3'd4: return 8'h0D;
      3'd5: return 8'hF0;
      3'd6: return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/uart_rb_decode.sv
module uart_rb_decode #(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              low_hit,
  output logic [4:0]        sel,
  output logic              id_hit,
  output logic [2:0]        id_k
);
  localparam int TOP_W = ADDR_W - 5;

  assign low_hit = (addr[ADDR_W-1:7] == '0);
  assign sel     = addr[6:2];
  assign id_hit  = (addr[ADDR_W-1:5] == {TOP_W{1'b1}});
  assign id_k    = addr[4:2];

  always_comb begin
    assert (!(low_hit && id_hit)) else $error("assert_window_apart_R11");
  end
endmodule

// File: rtl/uart_rb_field.sv
module uart_rb_field #(
  parameter int          W   = 32,
  parameter logic [W-1:0] MSK = '1,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= RST;
    else if (we) q <= wdata & MSK;
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(q));
endmodule

// File: rtl/uart_rb_irq.sv
module uart_rb_irq
  import uart_rb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             mask_we,
  input  logic [IRQ_W-1:0] mask_wdata,
  input  logic             clr_we,
  input  logic [IRQ_W-1:0] clr_wdata,
  input  logic             tx_set,
  input  logic             rx_set,
  input  logic             rx_clr,
  output logic [IRQ_W-1:0] raw,
  output logic [IRQ_W-1:0] mask,
  output logic             irq
);
  logic [IRQ_W-1:0] raw_nx;

  // clears first, then set events, so a set in the same cycle wins
  always_comb begin
    raw_nx = raw & ~(clr_we ? clr_wdata : '0);
    if (rx_clr) raw_nx[BIT_RXI] = 1'b0;
    if (tx_set) raw_nx[BIT_TXI] = 1'b1;
    if (rx_set) raw_nx[BIT_RXI] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw  <= '0;
      mask <= '0;
    end else begin
      raw <= raw_nx;
      if (mask_we) mask <= mask_wdata;
    end
  end

  assign irq = |(raw & mask);

  assert_tx_set_R3: assert property (@(posedge clk) disable iff (rst)
    tx_set |=> raw[BIT_TXI]);
  assert_rx_set_R7: assert property (@(posedge clk) disable iff (rst)
    rx_set |=> raw[BIT_RXI]);
  assert_rx_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (rx_clr && !rx_set) |=> !raw[BIT_RXI]);
  assert_clear_tx_R8: assert property (@(posedge clk) disable iff (rst)
    (clr_we && clr_wdata[BIT_TXI] && !tx_set) |=> !raw[BIT_TXI]);
  assert_mask_R9: assert property (@(posedge clk) disable iff (rst)
    mask_we |=> (mask == $past(mask_wdata)));
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_rb_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int RXW_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  output logic              tx_push,
  output logic [7:0]        tx_byte,
  input  logic              txp_empty,
  input  logic              txp_full,
  output logic              rx_pop,
  input  logic [RXW_W-1:0]  rx_word,
  input  logic              rxf_empty,
  input  logic              rxf_full,
  input  logic              rxf_hit,
  input  logic              rxf_drop,
  output logic              irq
);
  localparam int RSR_W = RXW_W - 8;

  logic             low_hit, id_hit;
  logic [4:0]       sel;
  logic [2:0]       id_k;
  logic [3:0]       flags_q;
  logic [RSR_W-1:0] rsr_q;
  logic [IRQ_W-1:0] raw, mask;
  logic [NCFG-1:0][31:0] cfg_q;
  logic [31:0]      rd_mux;

  // named access events
  logic wr_low, data_wr, data_rd, rsr_wr, mask_wr, clr_wr;
  assign wr_low  = bus_wr && low_hit;
  assign data_wr = wr_low && (sel == IDX_DATA);
  assign data_rd = bus_rd && low_hit && (sel == IDX_DATA);
  assign rsr_wr  = wr_low && (sel == IDX_RSR);
  assign mask_wr = wr_low && (sel == IDX_MSK);
  assign clr_wr  = wr_low && (sel == IDX_ICL);

  uart_rb_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .low_hit(low_hit), .sel(sel),
    .id_hit(id_hit), .id_k(id_k)
  );

  generate
    for (genvar k = 0; k < NCFG; k++) begin : g_cfg
      uart_rb_field #(.W(32), .MSK(cfg_mask(k)), .RST(cfg_reset(k))) u_fld (
        .clk(clk), .rst(rst),
        .we(wr_low && (sel == cfg_index(k))),
        .wdata(bus_wdata), .q(cfg_q[k])
      );
    end
  endgenerate

  uart_rb_irq u_irq (
    .clk(clk), .rst(rst),
    .mask_we(mask_wr), .mask_wdata(bus_wdata[IRQ_W-1:0]),
    .clr_we(clr_wr), .clr_wdata(bus_wdata[IRQ_W-1:0]),
    .tx_set(data_wr), .rx_set(rxf_hit), .rx_clr(rxf_drop),
    .raw(raw), .mask(mask), .irq(irq)
  );

  assign tx_push = data_wr;
  assign tx_byte = bus_wdata[7:0];
  assign rx_pop  = data_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= 4'b1001;
      rsr_q   <= '0;
    end else begin
      flags_q <= {txp_empty, rxf_full, txp_full, rxf_empty};
      if (rsr_wr)       rsr_q <= '0;
      else if (data_rd) rsr_q <= rx_word[RXW_W-1:8];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (id_hit) begin
      rd_mux = {24'b0, id_byte(id_k)};
    end else if (low_hit) begin
      case (sel)
        IDX_DATA: rd_mux = 32'(rx_word);
        IDX_RSR:  rd_mux = 32'(rsr_q);
        IDX_FLAG: rd_mux = {24'b0, flags_q, 4'b0};
        IDX_MSK:  rd_mux = 32'(mask);
        IDX_RAW:  rd_mux = 32'(raw);
        IDX_MIS:  rd_mux = 32'(raw & mask);
        default: begin
          for (int k = 0; k < NCFG; k++)
            if (sel == cfg_index(k)) rd_mux = cfg_q[k];
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assert_rsr_clear_R5: assert property (@(posedge clk) disable iff (rst)
    rsr_wr |=> (rsr_q == '0));
  assert_pop_data_R4: assert property (@(posedge clk) disable iff (rst)
    rx_pop |=> (bus_rdata == 32'($past(rx_word))));
  assert_unmapped_zero_R12: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !low_hit && !id_hit) |=> (bus_rdata == '0));
  assert_id_byte_R11: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && id_hit) |=> (bus_rdata[31:8] == '0));
  assert_push_one_R3: assert property (@(posedge clk) disable iff (rst)
    tx_push |-> !rx_pop);
endmodule

// File: tb/test_uart_regbank.sv
module test_uart_regbank;
  localparam int PERIOD = 10;

  logic        clk = 0;
  logic        rst = 1;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tx_push, rx_pop, irq;
  logic [7:0]  tx_byte;
  logic        txp_empty = 1, txp_full = 0, rxf_empty = 1, rxf_full = 0;
  logic        rxf_hit = 0, rxf_drop = 0;
  logic [11:0] rx_word = '0;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model
  logic [31:0] m_cfg [0:6];
  logic [10:0] m_raw, m_mask;
  logic [3:0]  m_rsr;

  always #(PERIOD/2) clk = ~clk;

  uart_regbank i_uart_regbank (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .tx_push(tx_push), .tx_byte(tx_byte), .txp_empty(txp_empty),
    .txp_full(txp_full), .rx_pop(rx_pop), .rx_word(rx_word),
    .rxf_empty(rxf_empty), .rxf_full(rxf_full), .rxf_hit(rxf_hit),
    .rxf_drop(rxf_drop), .irq(irq)
  );

  function automatic int slot_of(input int idx);
    case (idx)
      8: return 0; 9: return 1; 10: return 2; 11: return 3;
      12: return 4; 13: return 5; 18: return 6;
      default: return -1;
    endcase
  endfunction

  function automatic logic [31:0] width_mask(input int s);
    int w;
    case (s)
      0, 3: w = 8;
      1, 4: w = 16;
      2, 5: w = 6;
      default: w = 3;
    endcase
    return (32'd1 << w) - 1;
  endfunction

  function automatic logic [7:0] ident(input int k);
    logic [7:0] t [0:7] = '{8'h11, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    return t[k];
  endfunction

  function automatic logic [31:0] model_read(input logic [11:0] a);
    int idx = int'(a[11:2]);
    if (a >= 12'hFE0) return {24'b0, ident(int'(a[4:2]))};
    if (idx >= 32) return 0;
    case (idx)
      0:  return {20'b0, rx_word};
      1:  return {28'b0, m_rsr};
      6:  return {24'b0, txp_empty, rxf_full, txp_full, rxf_empty, 4'b0};
      14: return {21'b0, m_mask};
      15: return {21'b0, m_raw};
      16: return {21'b0, m_raw & m_mask};
      default: return (slot_of(idx) >= 0) ? m_cfg[slot_of(idx)] : 32'h0;
    endcase
  endfunction

  function automatic string req_of(input logic [11:0] a);
    int idx = int'(a[11:2]);
    if (a >= 12'hFE0) return "R11";
    if (idx >= 32) return "R12";
    case (idx)
      0: return "R4";
      1: return "R5";
      6: return "R6";
      14, 15, 16: return "R9";
      default: return (slot_of(idx) >= 0) ? "R2" : "R12";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic wr, rd, input logic [11:0] a,
                      input logic [31:0] d, input logic rs, rc);
    logic [31:0] exp_rd;
    int idx;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    rxf_hit = rs; rxf_drop = rc;
    rx_word = 12'($urandom);
    idx = (a < 12'h080) ? int'(a[6:2]) : -1;
    #1;
    check("R3 push", {31'b0, tx_push}, {31'b0, wr && idx == 0});
    if (wr && idx == 0) check("R3 byte", {24'b0, tx_byte}, {24'b0, d[7:0]});
    check("R4 pop", {31'b0, rx_pop}, {31'b0, rd && idx == 0});
    exp_rd = model_read(a);
    @(posedge clk);
    #1;
    bus_wr = 0; bus_rd = 0; rxf_hit = 0; rxf_drop = 0;
    if (wr) begin
      if (idx == 0) m_raw[5] = 1'b1;
      if (idx == 1) m_rsr = 4'h0;
      if (idx == 14) m_mask = d[10:0];
      if (idx == 17) m_raw = m_raw & ~d[10:0];
      if (idx >= 0 && slot_of(idx) >= 0) m_cfg[slot_of(idx)] = d & width_mask(slot_of(idx));
    end
    if (rc) m_raw[4] = 1'b0;
    if (rs) m_raw[4] = 1'b1;
    if (rd && idx == 0) m_rsr = rx_word[11:8];
    if (rd) check(req_of(a), bus_rdata, exp_rd);
    check("R10 irq", {31'b0, irq}, {31'b0, |(m_raw & m_mask)});
  endtask

  task automatic rd(input logic [11:0] a);
    step(0, 1, a, '0, 0, 0);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    step(1, 0, a, d, 0, 0);
  endtask

  task automatic set_flags(input logic [3:0] f);
    @(negedge clk);
    {txp_empty, rxf_full, txp_full, rxf_empty} = f;
    @(posedge clk);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int s = 0; s < 7; s++) m_cfg[s] = 0;
    m_cfg[4] = 32'h300; m_cfg[5] = 32'h12;
    m_raw = '0; m_mask = '0; m_rsr = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state, before any access
    check("R1 rdata", bus_rdata, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    @(negedge clk); rst = 0;
    @(posedge clk);
    rd(12'h018); // flags 0x90, R1
    check("R1 flags", bus_rdata, 32'h90);
    rd(12'h034); check("R1 ifls", bus_rdata, 32'h12);
    rd(12'h030); check("R1 ctrl", bus_rdata, 32'h300);
    for (int i = 0; i < 32; i++) rd(12'(i * 4));

    // R11: identification window
    for (int k = 0; k < 8; k++) rd(12'hFE0 + 12'(k * 4));
    wr(12'hFE8, 32'hFFFF_FFFF); rd(12'hFE8);

    // R2: settings width masking
    for (int i = 8; i <= 18; i++) wr(12'(i * 4), 32'hFFFF_FFFF);
    rd(12'h020); rd(12'h028); rd(12'h048); rd(12'h030);

    // R6: flag write ignored, flags follow inputs
    set_flags(4'b0110);
    wr(12'h018, 32'hFFFF_FFFF); rd(12'h018);
    set_flags(4'b1001);

    // R3 / R10: transmit interrupt through mask
    wr(12'h038, 32'h20); wr(12'h000, 32'h5A);
    check("R10 tx irq", {31'b0, irq}, 32'h1);
    wr(12'h044, 32'h20); // R8 clear
    check("R8 cleared", {31'b0, irq}, 32'h0);

    // R7: set wins over drop
    wr(12'h038, 32'h30);
    step(0, 0, 12'h0, 0, 1, 1); rd(12'h03C);
    step(0, 0, 12'h0, 0, 0, 1); rd(12'h03C);
    // R8: clear write collides with set event, set wins
    step(1, 0, 12'h044, 32'h7FF, 1, 0); rd(12'h03C);
    check("R8 collide", {31'b0, irq}, 32'h1);

    // R4 / R5: receive status captured then cleared
    rd(12'h000); rd(12'h004); wr(12'h004, 32'h0); rd(12'h004);

    // R12: writes far outside the map
    wr(12'h800, 32'hFFFF_FFFF); wr(12'h008, 32'hFFFF_FFFF); rd(12'h800);

    // random mix
    for (int n = 0; n < 600; n++) begin
      int op = int'($urandom % 10);
      logic [11:0] a;
      case ($urandom % 4)
        0: a = 12'hFE0 + 12'(($urandom % 8) * 4);
        1: a = 12'($urandom);
        default: a = 12'(($urandom % 32) * 4) | 12'($urandom % 4);
      endcase
      case (op)
        0, 1, 2: step(1, 0, a, $urandom, 0, 0);
        3, 4, 5: step(0, 1, a, 0, 0, 0);
        6: step(0, 0, a, 0, 1'($urandom), 1'($urandom));
        7: set_flags(4'($urandom));
        8: step(1, 0, 12'h044, $urandom, 1'($urandom), 1'($urandom));
        default: step(1, 0, 12'h038, $urandom, 0, 0);
      endcase
    end
    for (int i = 0; i < 20; i++) rd(12'(i * 4));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule